// File: doc/BRIEF.md
# Forwarding Three-Stage ALU Pipeline

This block is a compact in-order execution datapath. Every clock cycle it takes one already-decoded instruction. The instruction carries a 3-bit operation code, two source register numbers, a destination register number and a squash flag. The instruction moves through three steps: operand capture, ALU evaluation and write-back into a private register file. The file has two read ports and one write port. Operand capture bypasses the file with the live ALU result or the pending write-back value whenever a recent instruction targets the same register. A dependent instruction can therefore issue in the very next cycle with no interlock.

A squashed instruction still moves down the pipe. It never writes the file, and its result is never bypassed to a younger instruction. Each squash flag and destination is delayed with its instruction, so bypass and write-back are gated per stage. The architectural effect of an instruction issued in cycle t becomes visible in cycle t+3. A third, asynchronous read port lets an observer inspect any register. Synchronous reset gives every register file entry a known starting value and marks both delayed squash flags as set.

Top module: `fwd_alu_pipe`

## Requirements
- R1: An unsquashed instruction issued in cycle t has its result readable at its destination through the debug port from cycle t+3 onward. In cycle t+3 the file equals that of a sequential machine that has executed every instruction up to and including the one issued in cycle t.
- R2: Operation codes: 0 add, 1 subtract (src_a minus src_b), 2 bitwise AND, 3 bitwise OR, 4 bitwise XOR, 5 shift src_a left by the low log2(DW) bits of src_b, 6 shift src_a right logically by those bits, 7 pass src_b. Results wrap to DW bits.
- R3: An instruction reading the destination of the instruction issued one cycle earlier sees that instruction's result.
- R4: An instruction reading the destination of the instruction issued two cycles earlier sees that instruction's result, even when the instruction between them is unrelated or squashed.
- R5: When the two previous instructions both wrote the register being read, the more recent result is used.
- R6: A squashed instruction leaves every register file entry unchanged.
- R7: A squashed instruction's result is never forwarded: younger readers see the value the register held before it.
- R8: When both sources name the same register, both operands receive the same value.
- R9: While reset is asserted, entry i is loaded with (i+1) x 0x9E3779B1 modulo 2^DW, and both delayed squash flags are set. As a result, the first two cycles after reset perform no write.
- R10: The debug read port returns the addressed entry combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_op | input | 3 | Operation code of the issuing instruction |
| in_src_a | input | AW | First source register number |
| in_src_b | input | AW | Second source register number |
| in_dst | input | AW | Destination register number |
| in_squash | input | 1 | Marks the issuing instruction as aborted |
| dbg_addr | input | AW | Register number for the observation port |
| dbg_data | output | DW | Contents of the register named by dbg_addr |

## Verification
Directed sequences isolate each bypass case in turn. One reads a result one instruction later, one reads it two instructions later across an unrelated or squashed gap, one has two consecutive writers of the same register, and one reads the same register on both sources. A wrong priority or a missing squash gate then gives a value that differs from the sequential model. A walk through all eight operation codes separates the ALU functions. A long random stream with destinations drawn from a few registers creates dense collisions and frequent squashes. Each cycle it compares the debug read of the instruction issued three cycles earlier against a sequential reference. Any change in latency or a lost write shows up as a mismatch.

// File: rtl/fap_pkg.sv
package fap_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_SHL   = 3'd5,
        OP_SHR   = 3'd6,
        OP_PASSB = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_FILE = 2'd0,
        SRC_WB   = 2'd1,
        SRC_ALU  = 2'd2
    } opnd_src_e;

    localparam logic [63:0] INIT_MULT = 64'h0000_0000_9E37_79B1;

endpackage

// File: rtl/fap_alu.sv
module fap_alu
    import fap_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    localparam int SHW = (DW > 1) ? $clog2(DW) : 1;

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        unique case (op)
            OP_ADD:   y = a + b;
            OP_SUB:   y = a - b;
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_SHL:   y = a << shamt;
            OP_SHR:   y = a >> shamt;
            default:  y = b;
        endcase
    end
endmodule

// File: rtl/fap_fwd_sel.sv
module fap_fwd_sel
    import fap_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_kill,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_kill,
    input  logic [DW-1:0] alu_val,
    input  logic [DW-1:0] wb_val,
    input  logic [DW-1:0] file_val,
    output logic [DW-1:0] operand
);
    opnd_src_e pick;

    always_comb begin
        if (src == ex_dst && !ex_kill)
            pick = SRC_ALU;
        else if (src == wb_dst && !wb_kill)
            pick = SRC_WB;
        else
            pick = SRC_FILE;
    end

    always_comb begin
        unique case (pick)
            SRC_ALU: operand = alu_val;
            SRC_WB:  operand = wb_val;
            default: operand = file_val;
        endcase
    end
endmodule

// File: rtl/fap_regfile.sv
module fap_regfile
    import fap_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0][AW-1:0]    rd_addr,
    output logic [1:0][DW-1:0]    rd_data,
    input  logic [AW-1:0]         obs_addr,
    output logic [DW-1:0]         obs_data,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data
);
    logic [DEPTH-1:0][DW-1:0] mem;

    function automatic logic [DW-1:0] init_word(input int idx);
        logic [63:0] prod;
        prod = 64'(idx + 1) * INIT_MULT;
        return DW'(prod);
    endfunction

    function automatic logic [DW-1:0] fetch(input logic [AW-1:0] a,
                                            input logic [DEPTH-1:0][DW-1:0] m);
        if (int'(a) < DEPTH) return m[a];
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
        end else if (wr_en && int'(wr_addr) < DEPTH) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data[p] = fetch(rd_addr[p], mem);
    end
    assign obs_data = fetch(obs_addr, mem);

    // R6: with no write enabled the whole array holds.
    p_hold_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem));

    // R1: an enabled write is observable at its address one edge later.
    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) < DEPTH) |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/fwd_alu_pipe.sv
module fwd_alu_pipe
    import fap_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    in_op,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    input  logic [AW-1:0] in_dst,
    input  logic          in_squash,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data
);
    // Execute stage (one cycle after issue)
    alu_op_e              ex_op;
    logic [AW-1:0]        ex_dst;
    logic                 ex_kill;
    logic [1:0][DW-1:0]   ex_opnd;
    logic [DW-1:0]        alu_y;

    // Write-back stage (two cycles after issue)
    logic [AW-1:0]        wb_dst;
    logic                 wb_kill;
    logic [DW-1:0]        wb_val;

    logic [1:0][AW-1:0]   src_vec;
    logic [1:0][DW-1:0]   file_rd;
    logic [1:0][DW-1:0]   opnd_next;

    assign src_vec = {in_src_b, in_src_a};

    fap_regfile #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (src_vec),
        .rd_data  (file_rd),
        .obs_addr (dbg_addr),
        .obs_data (dbg_data),
        .wr_en    (!wb_kill),
        .wr_addr  (wb_dst),
        .wr_data  (wb_val)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        fap_fwd_sel #(.DW(DW), .AW(AW)) u_sel (
            .src      (src_vec[p]),
            .ex_dst   (ex_dst),
            .ex_kill  (ex_kill),
            .wb_dst   (wb_dst),
            .wb_kill  (wb_kill),
            .alu_val  (alu_y),
            .wb_val   (wb_val),
            .file_val (file_rd[p]),
            .operand  (opnd_next[p])
        );
    end

    fap_alu #(.DW(DW)) u_alu (
        .op (ex_op),
        .a  (ex_opnd[0]),
        .b  (ex_opnd[1]),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_op   <= OP_ADD;
            ex_dst  <= '0;
            ex_kill <= 1'b1;
            ex_opnd <= '0;
            wb_dst  <= '0;
            wb_kill <= 1'b1;
            wb_val  <= '0;
        end else begin
            ex_op   <= alu_op_e'(in_op);
            ex_dst  <= in_dst;
            ex_kill <= in_squash;
            ex_opnd <= opnd_next;
            wb_dst  <= ex_dst;
            wb_kill <= ex_kill;
            wb_val  <= alu_y;
        end
    end

    // R3: a live-result match loads the ALU output into the operand register.
    p_fwd_live_r3: assert property (@(posedge clk) disable iff (rst)
        (in_src_a == ex_dst && !ex_kill) |=> ex_opnd[0] == $past(alu_y));

    // R4: a write-back match without a newer match loads the pending value.
    p_fwd_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (in_src_b == wb_dst && !wb_kill && !(in_src_b == ex_dst && !ex_kill))
        |=> ex_opnd[1] == $past(wb_val));

    // R8: identical sources give identical operands.
    p_same_src_r8: assert property (@(posedge clk) disable iff (rst)
        (in_src_a == in_src_b) |=> ex_opnd[0] == ex_opnd[1]);

    // R9: reset leaves both delayed squash flags set.
    p_reset_kill_r9: assert property (@(posedge clk)
        rst |=> (ex_kill && wb_kill));

    // R7: a squashed instruction's result is not what a later matching reader captures,
    // unless a stage older than it supplies the same value.
    p_no_fwd_squashed_r7: assert property (@(posedge clk) disable iff (rst)
        (in_src_a == ex_dst && ex_kill && !(in_src_a == wb_dst && !wb_kill))
        |=> ex_opnd[0] == $past(file_rd[0]));
endmodule

// File: tb/fwd_alu_pipe_tb.sv
module fwd_alu_pipe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 32;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int N_RANDOM = 1500;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    in_op = '0;
    logic [AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic          in_squash = 1'b1;
    logic [AW-1:0] dbg_addr = '0;
    logic [DW-1:0] dbg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [DW-1:0] ref_rf [DEPTH];
    logic [AW-1:0] ring_dst [4];
    logic [DW-1:0] ring_val [4];
    string         ring_tag [4];
    int            n_issued = 0;

    fwd_alu_pipe #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk, .rst, .in_op, .in_src_a, .in_src_b, .in_dst, .in_squash,
        .dbg_addr, .dbg_data
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] ref_alu(input int op, input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << b[4:0];
            6: return a >> b[4:0];
            default: return b;
        endcase
    endfunction

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One cycle: compare the instruction three cycles back, then issue a new one.
    task automatic issue(input int op, input int a, input int b, input int d,
                         input bit sq, input string tag);
        logic [DW-1:0] res;
        int slot;
        @(negedge clk);
        if (n_issued >= 3) begin
            slot = (n_issued - 3) % 4;
            dbg_addr = ring_dst[slot];
            #1;
            check(ring_tag[slot], dbg_data, ring_val[slot]);
        end
        in_op = 3'(op); in_src_a = AW'(a); in_src_b = AW'(b);
        in_dst = AW'(d); in_squash = sq;
        res = ref_alu(op, ref_rf[a], ref_rf[b]);
        if (!sq) ref_rf[d] = res;
        slot = n_issued % 4;
        ring_dst[slot] = AW'(d);
        ring_val[slot] = ref_rf[d];
        ring_tag[slot] = tag;
        n_issued++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) ref_rf[i] = 32'((i + 1) * 32'h9E3779B1);
        repeat (3) @(posedge clk);
        // R9 and R10: reset contents seen through the debug port.
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            dbg_addr = AW'(i);
            #1;
            check("R9/R10 reset content", dbg_data, ref_rf[i]);
        end
        rst = 1'b0;
        // R9: first instructions after reset land correctly with no stray write.
        issue(0, 1, 2, 3, 0, "R9 first after reset");
        // R2: each operation code.
        for (int op = 0; op < 8; op++) issue(op, 4 + op % 3, 9, 8, 0, "R2 opcode");
        issue(5, 2, 1, 9, 0, "R2 shift left");
        issue(6, 2, 1, 10, 0, "R2 shift right");
        // R3: back-to-back dependence.
        issue(0, 2, 3, 1, 0, "R3 setup");
        issue(4, 1, 5, 4, 0, "R3 live forward");
        // R4: gap of one unrelated and one squashed instruction.
        issue(0, 7, 8, 6, 0, "R4 setup");
        issue(1, 2, 3, 12, 0, "R4 filler");
        issue(1, 6, 10, 9, 0, "R4 write-back forward");
        issue(0, 7, 2, 6, 0, "R4 setup2");
        issue(0, 1, 1, 13, 1, "R4 squashed gap");
        issue(7, 0, 6, 9, 0, "R4 forward over squash");
        // R5: two consecutive writers then a reader.
        issue(0, 1, 2, 11, 0, "R5 older writer");
        issue(1, 3, 4, 11, 0, "R5 newer writer");
        issue(7, 0, 11, 12, 0, "R5 newest wins");
        // R7 and R6: squashed result not forwarded, not written.
        issue(3, 1, 2, 14, 1, "R6 squashed write");
        issue(7, 0, 14, 15, 0, "R7 no live forward");
        issue(2, 14, 3, 13, 0, "R7 no write-back forward");
        // R8: same register on both sources, straight after its write.
        issue(6, 5, 1, 5, 0, "R8 setup");
        issue(1, 5, 5, 3, 0, "R8 same source sub");
        issue(0, 5, 5, 2, 0, "R8 same source add");
        // R1/R6: random stream with dense collisions.
        for (int k = 0; k < N_RANDOM; k++) begin
            int a, b, d, op;
            bit sq, narrow;
            narrow = ($urandom % 2) == 0;
            a  = narrow ? $urandom % 4 : $urandom % DEPTH;
            b  = narrow ? $urandom % 4 : $urandom % DEPTH;
            d  = narrow ? $urandom % 4 : $urandom % DEPTH;
            op = $urandom % 8;
            sq = ($urandom % 5) == 0;
            issue(op, a, b, d, sq, sq ? "R6 random squash" : "R1 random");
        end
        for (int k = 0; k < 3; k++) issue(0, 0, 0, 0, 1, "R1 drain");
        // Final sweep of every entry through the debug port.
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            dbg_addr = AW'(i);
            #1;
            check("R1 final file", dbg_data, ref_rf[i]);
        end
        finish_run();
    end
endmodule